// File: doc/BRIEF.md
# DRAM Refresh and Initialisation Scheduler

This block brings a two-bank EDO DRAM array out of power-up and keeps it refreshed. After reset it holds every strobe inactive for a programmable pause. It then runs a fixed number of wake-up refresh cycles without asking anyone's permission, and only then raises its ready flag. From that point a free-running interval timer adds one refresh to a pending count on every period. While refreshes are pending, the block asks the access sequencer for the strobe lines through a request/grant pair.

A granted refresh drives one of two strobe patterns, picked at the start of each sequence by a mode input. In the CAS-before-RAS pattern, CAS leads RAS low and stays low for the whole RAS pulse, with WE held high. In the row-only pattern, CAS stays high while a row address from an internal wrapping counter is placed on the address bus. Every bank's RAS line pulses together, and each pulse honours the minimum low time and the minimum precharge time.

Pending refreshes are never dropped. When the backlog grows past a threshold, the block takes the strobes without waiting for the grant.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted, all RAS lines and CAS are high (inactive), and the request, active, ready and address-drive outputs are low.
- R2: The first refresh strobe edge comes exactly INIT_WAIT_CYC+1 clock cycles after reset is released. In CAS-before-RAS mode this edge is CAS falling.
- R3: Exactly WARMUP_CNT refresh pulses are issued before `init_done_o` rises. No request is raised before `init_done_o` is high.
- R4: A CAS-before-RAS refresh drives CAS low for exactly CSR_CYC cycles before RAS falls. CAS then stays low for every cycle RAS is low. WE stays high at all times.
- R5: A row-only refresh keeps CAS high for the whole pulse and asserts `addr_oe_o` exactly while RAS is low. `addr_oe_o` is low in every other cycle and in CAS-before-RAS pulses.
- R6: Each RAS low pulse lasts exactly RAS_LOW_CYC cycles. Each RAS high gap between pulses lasts at least RAS_PRE_CYC cycles. CAS is high in the cycle RAS rises.
- R7: All BANKS RAS outputs are identical in every cycle.
- R8: One interval tick occurs every REF_INTERVAL_CYC cycles after ready. With no backlog, `ref_req_o` rises REF_INTERVAL_CYC+1 cycles after the cycle in which `init_done_o` rose.
- R9: While requesting, with the pending count at or below FORCE_THRESH, no refresh starts unless `ref_gnt_i` is high. `ref_req_o` and `ref_active_o` are never high together.
- R10: Every interval tick produces exactly one refresh pulse, including ticks that arrive while an earlier refresh is still waiting for its grant.
- R11: Once the pending count exceeds FORCE_THRESH, the refresh starts in the next cycle without a grant.
- R12: The row address shown in a row-only refresh counts row-only refreshes since reset, modulo 2^ROW_W. CAS-before-RAS refreshes leave it unchanged.
- R13: The mode input is sampled when a sequence starts. A change while the sequence runs does not alter that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cbr_mode_i | input | 1 | 1 selects CAS-before-RAS refresh, 0 selects row-only refresh |
| ref_gnt_i | input | 1 | Grant of the strobe lines from the access sequencer |
| ref_req_o | output | 1 | Refresh request to the access sequencer |
| ref_active_o | output | 1 | Block owns the strobe lines (sequence running) |
| init_done_o | output | 1 | Power-up pause and wake-up refreshes complete |
| ras_n_o | output | BANKS | RAS strobes, one per bank, active low |
| cas_n_o | output | 1 | CAS strobe, active low |
| we_n_o | output | 1 | Write enable, active low, held high |
| addr_oe_o | output | 1 | Drive `row_addr_o` onto the address bus |
| row_addr_o | output | ROW_W | Row address for row-only refresh |

## Verification
The bench builds the block with a 20-cycle pause, 3 wake-up pulses, a 40-cycle interval, a 2/4/3-cycle CAS lead, RAS low and precharge, a 4-bit row counter and a force threshold of 2. At these values the exact cycle of the first strobe, the first request and the forced start can be computed from the parameters alone. Twenty-nine row-only refreshes carry the row counter through its wrap. Forty interval ticks can be matched one-for-one against RAS pulses while the grant is first withheld and then held high. A mode flip during the CAS lead of a sequence shows that the pulse already started keeps its mode.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  typedef enum logic [2:0] {
    S_PAUSE,
    S_IDLE,
    S_REQ,
    S_CSR,
    S_RAS,
    S_PRE
  } rfs_state_e;
endpackage

// File: rtl/rfs_tick_gen.sv
module rfs_tick_gen #(
  parameter int INIT_WAIT_CYC    = 20000,
  parameter int REF_INTERVAL_CYC = 1560
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic pause_done_o,
  output logic tick_o
);
  localparam int PW = $clog2(INIT_WAIT_CYC + 1);
  localparam int IW = $clog2(REF_INTERVAL_CYC + 1);

  logic [PW-1:0] pause_cnt_q;
  logic [IW-1:0] ivl_cnt_q;
  logic          pause_done_q;

  assign pause_done_o = pause_done_q;
  assign tick_o       = en_i && (ivl_cnt_q == IW'(REF_INTERVAL_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pause_cnt_q  <= '0;
      pause_done_q <= 1'b0;
    end else if (!pause_done_q) begin
      if (pause_cnt_q == PW'(INIT_WAIT_CYC - 1)) pause_done_q <= 1'b1;
      else pause_cnt_q <= pause_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ivl_cnt_q <= '0;
    else if (!en_i)  ivl_cnt_q <= '0;
    else if (tick_o) ivl_cnt_q <= '0;
    else             ivl_cnt_q <= ivl_cnt_q + 1'b1;
  end

  a_r8_no_tick_before_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pause_done_q |-> !tick_o);
endmodule

// File: rtl/rfs_pend_ctr.sv
module rfs_pend_ctr #(
  parameter int PEND_W       = 4,
  parameter int FORCE_THRESH = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  output logic pending_o,
  output logic force_o
);
  localparam logic [PEND_W-1:0] PMAX = '1;

  logic [PEND_W-1:0] pend_q;

  assign pending_o = (pend_q != '0);
  assign force_o   = (pend_q > PEND_W'(FORCE_THRESH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else begin
      unique case ({inc_i, dec_i})
        2'b10:   if (pend_q != PMAX) pend_q <= pend_q + 1'b1;
        2'b01:   if (pend_q != '0)   pend_q <= pend_q - 1'b1;
        default: pend_q <= pend_q;
      endcase
    end
  end

  a_r10_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q == PMAX && inc_i && !dec_i) |=> (pend_q == PMAX));
  a_r10_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q == '0) |-> !dec_i);
endmodule

// File: rtl/rfs_row_ctr.sv
module rfs_row_ctr #(
  parameter int ROW_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [ROW_W-1:0] row_o
);
  logic [ROW_W-1:0] row_q;

  assign row_o = row_q;

  // natural wrap at 2^ROW_W
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    row_q <= '0;
    else if (inc_i) row_q <= row_q + 1'b1;
  end

  a_r12_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(row_q));
endmodule

// File: rtl/rfs_seq_fsm.sv
module rfs_seq_fsm
  import rfs_pkg::*;
#(
  parameter int WARMUP_CNT  = 8,
  parameter int CSR_CYC     = 2,
  parameter int RAS_LOW_CYC = 6,
  parameter int RAS_PRE_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pause_done_i,
  input  logic pending_i,
  input  logic force_i,
  input  logic gnt_i,
  input  logic cbr_mode_i,
  output logic init_done_o,
  output logic req_o,
  output logic active_o,
  output logic ras_lo_o,
  output logic cas_lo_o,
  output logic addr_oe_o,
  output logic done_o,
  output logic row_inc_o
);
  localparam int TMAX = (CSR_CYC > RAS_LOW_CYC) ?
                        ((CSR_CYC > RAS_PRE_CYC) ? CSR_CYC : RAS_PRE_CYC) :
                        ((RAS_LOW_CYC > RAS_PRE_CYC) ? RAS_LOW_CYC : RAS_PRE_CYC);
  localparam int TW = $clog2(TMAX + 1);
  localparam int WW = $clog2(WARMUP_CNT + 1);

  rfs_state_e    state_q;
  logic [TW-1:0] tmr_q;
  logic [WW-1:0] wcnt_q;
  logic          init_done_q;
  logic          cyc_cbr_q;

  rfs_state_e    start_st;
  logic [TW-1:0] start_tmr;
  logic          tmr_zero;

  assign start_st  = cbr_mode_i ? S_CSR : S_RAS;
  assign start_tmr = cbr_mode_i ? TW'(CSR_CYC - 1) : TW'(RAS_LOW_CYC - 1);
  assign tmr_zero  = (tmr_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_PAUSE;
      tmr_q       <= '0;
      wcnt_q      <= '0;
      init_done_q <= 1'b0;
      cyc_cbr_q   <= 1'b1;
    end else begin
      unique case (state_q)
        S_PAUSE: if (pause_done_i) begin
          state_q <= start_st; tmr_q <= start_tmr; cyc_cbr_q <= cbr_mode_i;
        end
        S_IDLE: if (pending_i) state_q <= S_REQ;
        S_REQ: if (gnt_i || force_i) begin
          state_q <= start_st; tmr_q <= start_tmr; cyc_cbr_q <= cbr_mode_i;
        end
        S_CSR: if (tmr_zero) begin
          state_q <= S_RAS; tmr_q <= TW'(RAS_LOW_CYC - 1);
        end else tmr_q <= tmr_q - 1'b1;
        S_RAS: if (tmr_zero) begin
          state_q <= S_PRE; tmr_q <= TW'(RAS_PRE_CYC - 1);
        end else tmr_q <= tmr_q - 1'b1;
        S_PRE: if (tmr_zero) begin
          if (init_done_q) state_q <= S_IDLE;
          else if (wcnt_q == WW'(WARMUP_CNT - 1)) begin
            init_done_q <= 1'b1; state_q <= S_IDLE;
          end else begin
            wcnt_q <= wcnt_q + 1'b1;
            state_q <= start_st; tmr_q <= start_tmr; cyc_cbr_q <= cbr_mode_i;
          end
        end else tmr_q <= tmr_q - 1'b1;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign init_done_o = init_done_q;
  assign req_o       = (state_q == S_REQ);
  assign active_o    = (state_q == S_CSR) || (state_q == S_RAS) || (state_q == S_PRE);
  assign ras_lo_o    = (state_q == S_RAS);
  assign cas_lo_o    = cyc_cbr_q && ((state_q == S_CSR) || (state_q == S_RAS));
  assign addr_oe_o   = !cyc_cbr_q && (state_q == S_RAS);
  assign done_o      = (state_q == S_RAS) && tmr_zero && init_done_q;
  assign row_inc_o   = (state_q == S_RAS) && tmr_zero && !cyc_cbr_q;

  a_r9_wait_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_REQ && !gnt_i && !force_i) |=> (state_q == S_REQ));
  a_r4_cas_leads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RAS && cyc_cbr_q) |-> $past(cas_lo_o));
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int BANKS            = 2,
  parameter int ROW_W            = 12,
  parameter int INIT_WAIT_CYC    = 20000,
  parameter int WARMUP_CNT       = 8,
  parameter int REF_INTERVAL_CYC = 1560,
  parameter int CSR_CYC          = 2,
  parameter int RAS_LOW_CYC      = 6,
  parameter int RAS_PRE_CYC      = 4,
  parameter int PEND_W           = 4,
  parameter int FORCE_THRESH     = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cbr_mode_i,
  input  logic             ref_gnt_i,
  output logic             ref_req_o,
  output logic             ref_active_o,
  output logic             init_done_o,
  output logic [BANKS-1:0] ras_n_o,
  output logic             cas_n_o,
  output logic             we_n_o,
  output logic             addr_oe_o,
  output logic [ROW_W-1:0] row_addr_o
);
  logic pause_done, tick, pending, force_gnt;
  logic ras_lo, cas_lo, seq_done, row_inc;

  rfs_tick_gen #(
    .INIT_WAIT_CYC   (INIT_WAIT_CYC),
    .REF_INTERVAL_CYC(REF_INTERVAL_CYC)
  ) u_tick (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (init_done_o),
    .pause_done_o(pause_done),
    .tick_o      (tick)
  );

  rfs_pend_ctr #(
    .PEND_W      (PEND_W),
    .FORCE_THRESH(FORCE_THRESH)
  ) u_pend (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (tick),
    .dec_i    (seq_done),
    .pending_o(pending),
    .force_o  (force_gnt)
  );

  rfs_seq_fsm #(
    .WARMUP_CNT (WARMUP_CNT),
    .CSR_CYC    (CSR_CYC),
    .RAS_LOW_CYC(RAS_LOW_CYC),
    .RAS_PRE_CYC(RAS_PRE_CYC)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pause_done_i(pause_done),
    .pending_i   (pending),
    .force_i     (force_gnt),
    .gnt_i       (ref_gnt_i),
    .cbr_mode_i  (cbr_mode_i),
    .init_done_o (init_done_o),
    .req_o       (ref_req_o),
    .active_o    (ref_active_o),
    .ras_lo_o    (ras_lo),
    .cas_lo_o    (cas_lo),
    .addr_oe_o   (addr_oe_o),
    .done_o      (seq_done),
    .row_inc_o   (row_inc)
  );

  rfs_row_ctr #(.ROW_W(ROW_W)) u_row (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (row_inc),
    .row_o (row_addr_o)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_ras
    assign ras_n_o[b] = !ras_lo;
  end

  assign cas_n_o = !cas_lo;
  assign we_n_o  = 1'b1;

  a_r3_no_req_before_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done_o |-> !ref_req_o);
  a_r9_req_vs_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_req_o |-> !ref_active_o);
  a_r6_cas_high_at_ras_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o[0]) |-> cas_n_o);
endmodule

// File: tb/dram_refresh_sched_tb_top.sv
module dram_refresh_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BANKS  = 2;
  localparam int ROW_W  = 4;
  localparam int WAIT_C = 20;
  localparam int WARM   = 3;
  localparam int IVL    = 40;
  localparam int CSR    = 2;
  localparam int RLOW   = 4;
  localparam int RPRE   = 3;
  localparam int PEND_W = 3;
  localparam int THR    = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cbr_mode = 1'b1;
  logic gnt = 1'b0;
  logic req, active, init_done, cas_n, we_n, addr_oe;
  logic [BANKS-1:0] ras_n;
  logic [ROW_W-1:0] row;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_refresh_sched #(
    .BANKS(BANKS), .ROW_W(ROW_W), .INIT_WAIT_CYC(WAIT_C), .WARMUP_CNT(WARM),
    .REF_INTERVAL_CYC(IVL), .CSR_CYC(CSR), .RAS_LOW_CYC(RLOW), .RAS_PRE_CYC(RPRE),
    .PEND_W(PEND_W), .FORCE_THRESH(THR)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cbr_mode_i(cbr_mode), .ref_gnt_i(gnt),
    .ref_req_o(req), .ref_active_o(active), .init_done_o(init_done),
    .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n), .addr_oe_o(addr_oe),
    .row_addr_o(row)
  );

  int vectors = 0;
  int fails = 0;
  bit finished = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_ni) cyc <= cyc + 1;

  // strobe monitor
  int  pulses = 0, ronly_n = 0, first_cas = -1;
  int  ras_run = 0, pre_run = 0, csr_run = 0;
  bit  prev_ras = 0, prev_cas = 1, pulse_cbr = 1, cas_lo_seen = 0, cas_hi_seen = 0, ras_lo;

  always @(negedge clk) begin
    if (rst_ni) begin
      ras_lo = (ras_n[0] == 1'b0);
      check(ras_n[0] == ras_n[1], "R7 bank RAS mismatch", int'(ras_n), {2{ras_n[0]}});
      check(we_n == 1'b1, "R4 WE high", int'(we_n), 1);
      check(!(req && !init_done), "R3 request before ready", int'(req), 0);
      if (!cas_n && prev_cas && first_cas < 0) first_cas = cyc;
      if (ras_lo && !prev_ras) begin
        if (pulses > 0) check(pre_run >= RPRE, "R6 precharge", pre_run, RPRE);
        pulse_cbr = !cas_n;
        if (pulse_cbr) check(csr_run == CSR, "R4 CAS lead", csr_run, CSR);
        else begin
          check(int'(row) == ronly_n % (1 << ROW_W), "R12 row address", int'(row),
                ronly_n % (1 << ROW_W));
          ronly_n++;
        end
        ras_run = 0; cas_lo_seen = 0; cas_hi_seen = 0;
      end
      if (!ras_lo && prev_ras) begin
        pulses++;
        check(ras_run == RLOW, "R6 RAS width", ras_run, RLOW);
        if (pulse_cbr) check(!cas_hi_seen, "R4 CAS hold", int'(cas_hi_seen), 0);
        else check(!cas_lo_seen, "R5 CAS stays high", int'(cas_lo_seen), 0);
        check(cas_n == 1'b1, "R6 CAS at RAS rise", int'(cas_n), 1);
        pre_run = 0;
      end
      if (ras_lo) begin
        ras_run++;
        if (cas_n) cas_hi_seen = 1; else cas_lo_seen = 1;
        check(addr_oe == !pulse_cbr, "R5 address drive", int'(addr_oe), int'(!pulse_cbr));
      end else begin
        pre_run++;
        csr_run = cas_n ? 0 : csr_run + 1;
        check(addr_oe == 1'b0, "R5 address idle", int'(addr_oe), 0);
      end
      prev_ras = ras_lo;
      prev_cas = cas_n;
    end
  end

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin
    int e;
    repeat (3) @(negedge clk);
    check(ras_n == '1, "R1 RAS in reset", int'(ras_n), 3);
    check(cas_n == 1'b1, "R1 CAS in reset", int'(cas_n), 1);
    check(!req && !active && !init_done && !addr_oe, "R1 outputs in reset",
          int'({req, active, init_done, addr_oe}), 0);
    rst_ni = 1'b1;

    while (!init_done && cyc < 2000) @(negedge clk);
    e = cyc;
    check(first_cas == WAIT_C + 1, "R2 first strobe cycle", first_cas, WAIT_C + 1);
    check(pulses == WARM, "R3 wake-up pulses", pulses, WARM);

    while (!req && cyc < e + 2 * IVL) @(negedge clk);
    check(cyc == e + IVL + 1, "R8 first request cycle", cyc, e + IVL + 1);

    // no grant: wait for forced start
    while (cas_n && cyc < e + 5 * IVL) begin
      check(!active, "R9 idle while ungranted", int'(active), 0);
      @(negedge clk);
    end
    check(cyc == e + 3 * IVL + 1, "R11 forced start cycle", cyc, e + 3 * IVL + 1);
    check(pulses == WARM, "R9 no refresh without grant", pulses, WARM);
    check(active && !req, "R9 active replaces request", int'({active, req}), 2);

    while (ras_n[0] == 1'b1) @(negedge clk);
    while (ras_n[0] == 1'b0) @(negedge clk);
    gnt = 1'b1;

    wait_cyc(e + 10 * IVL + IVL / 2);
    check(pulses - WARM == 10, "R10 pulses per tick", pulses - WARM, 10);

    cbr_mode = 1'b0;
    wait_cyc(e + 30 * IVL + IVL / 2);
    check(pulses - WARM == 30, "R10 pulses per tick", pulses - WARM, 30);
    check(ronly_n == 20, "R12 row-only count", ronly_n, 20);
    check(int'(row) == 20 % (1 << ROW_W), "R12 row wrapped", int'(row), 20 % (1 << ROW_W));

    // mode flip during CAS lead
    cbr_mode = 1'b1;
    while (cas_n) @(negedge clk);
    cbr_mode = 1'b0;
    while (ras_n[0]) @(negedge clk);
    check(cas_n == 1'b0, "R13 mode latched", int'(cas_n), 0);
    check(addr_oe == 1'b0, "R13 no address in latched CBR", int'(addr_oe), 0);

    wait_cyc(e + 40 * IVL + IVL / 2);
    check(pulses - WARM == 40, "R10 pulses per tick", pulses - WARM, 40);
    check(ronly_n == 29, "R12 CBR leaves row alone", ronly_n, 29);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule